// File: doc/BRIEF.md
# Two-Channel Modulo Timer with Break-Protected Flags

The block is a 16-bit up-counting timer. It counts to a programmable modulo limit, raises an overflow flag and wraps to zero. The count rate is either the bus clock divided by a power of two or the rising edges of an external clock input. That input is synchronised to the bus clock, so it must run at no more than half the bus rate. Two channels watch the counter. Each channel can latch the count on a rising edge of its input pin, or drive its output pin when the counter matches its value register. A compare channel either toggles its pin or forms a PWM wave whose period is set by the modulo register. Channel 0 can also borrow channel 1's value register to form a buffered pair: software loads the idle register, and the new value takes over at the next overflow, so a period never sees a half-updated width.

Software reaches the block through a byte-wide register port. It raises interrupts for overflow and for each channel. Every status flag clears in two steps: first a read of its register while the flag is set, then later a write of 0 to the flag bit. While a debug break is active and break clearing is not allowed, reads and writes leave the flags untouched. A first step taken before the break is remembered, so the second step after the break still clears the flag.

Top module: `dual_modulo_timer`

## Requirements
- R1: On each count tick the counter advances by one. A tick taken while the counter equals the modulo register (addresses 3 high and 4 low, reset 0xFFFF) sets the counter to 0 and sets the overflow flag (control register at address 0, bit 7). irq_ovf is the overflow flag ANDed with control bit 6.
- R2: With the control field bits 2:0 (PS) set to a value n from 0 to 6, a tick occurs once every 2^n bus cycles, counted from the last counter reset.
- R3: With PS = 7, the counter ticks once for each rising edge of ext_clk. The edge passes through a two-stage synchroniser, so it is seen on the third bus clock edge after the pin rises.
- R4: Control bit 5 stops the counter and holds its value (reset value 1, so the control register reads 0x20 after reset). Writing 1 to control bit 4 clears the counter and the prescaler to 0, and bit 4 always reads as 0. The counter reads at addresses 1 (high) and 2 (low).
- R5: A flag clears only when a write of 0 to its bit follows an earlier read of its register made while the flag was set. A write of 0 without that read leaves the flag set, and writing 1 never sets a flag.
- R6: While brk_act is 1 and brk_clr_en is 0, reads do not arm a clear and writes do not clear a flag. A read made before the break stays armed, so a write of 0 after the break clears the flag.
- R7: While brk_act is 1 and brk_clr_en is 1, the two-step clear works, and the flag stays cleared after the break ends.
- R8: A channel in capture mode latches the counter into its value register on a synchronised rising edge of its ch_in pin, and sets its flag. Channel control sits at 5 and 8, with bit 4 = 0 for capture. Value registers sit at 6/7 and 9/10, high byte first.
- R9: A channel in compare mode (control bit 4 = 1, bit 3 = 0) toggles its ch_out pin and sets its flag on each tick taken while the counter equals its value register.
- R10: In PWM mode (control bits 4 and 3 both 1), ch_out goes high at each overflow and low at the compare match. The pin is therefore high while the counter runs from 0 up to the value.
- R11: With channel 0 control bit 5 set (buffered), channel 0 compares against whichever value register was written last, and that choice takes effect only at the next overflow. Channel 1 is then idle and ch_out[1] stays 0.
- R12: irq_ch[i] is channel i's flag ANDed with its control bit 6. The channel flag occupies bit 7 of that channel's control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| brk_act | input | 1 | Debug break in progress |
| brk_clr_en | input | 1 | Allow flag clearing during a break |
| ext_clk | input | 1 | External count clock |
| ch_in | input | 2 | Channel capture inputs |
| ch_out | output | 2 | Channel compare/PWM outputs |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_ch | output | 2 | Channel interrupts |

## Verification
The bench targets the two-step clear: a blind write of 0, a read made during a frozen break, and a read made before a break that is completed after it. A design that cleared on any write of 0, or that let a frozen read arm the clear, would drop irq_ovf one access too early. The bench counts ticks after a counter reset at prescale 4 and with the external clock, so an off-by-one in the divider phase or in the synchroniser depth shows up as a wrong count. It changes the buffered PWM width mid-period and measures the duty, so a design that swapped registers at once rather than at overflow would produce a malformed period that the per-cycle model catches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_W = 4;
   localparam int PS_W   = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
   localparam logic [ADDR_W-1:0] A_CNT_H = 4'd1;
   localparam logic [ADDR_W-1:0] A_CNT_L = 4'd2;
   localparam logic [ADDR_W-1:0] A_MOD_H = 4'd3;
   localparam logic [ADDR_W-1:0] A_MOD_L = 4'd4;

   // control register bit positions
   localparam int B_FLAG = 7;
   localparam int B_IE   = 6;
   localparam int B_STOP = 5;
   localparam int B_RST  = 4;
   localparam int B_BUF  = 5;
   localparam int B_CMP  = 4;
   localparam int B_PWM  = 3;

   typedef struct packed {
      logic ie;
      logic buff;
      logic cmp;
      logic pwm;
   } chctl_t;

   function automatic logic [ADDR_W-1:0] ch_ctl_addr(input int idx);
      return ADDR_W'(5 + 3 * idx);
   endfunction

   function automatic logic [ADDR_W-1:0] ch_hi_addr(input int idx);
      return ADDR_W'(6 + 3 * idx);
   endfunction

   function automatic logic [ADDR_W-1:0] ch_lo_addr(input int idx);
      return ADDR_W'(7 + 3 * idx);
   endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync needs at least two stages");
   end

   logic [STAGES-1:0] shift_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         last_q  <= 1'b0;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], din};
         last_q  <= shift_q[STAGES-1];
      end
   end

   assign rise = shift_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick
   import tmr_pkg::*;
#(
   parameter int SYNC_N = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PS_W-1:0] ps,
   input  logic            stop,
   input  logic            clr,
   input  logic            ext_in,
   output logic            tick
);
   localparam int DIV_W = (1 << PS_W) - 2;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;
   logic             ext_rise;
   logic             use_ext;

   tmr_sync #(.STAGES(SYNC_N)) u_ext_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ext_in),
      .rise (ext_rise)
   );

   always_comb begin
      for (int b = 0; b < DIV_W; b++) mask[b] = (b < int'(ps));
   end

   assign use_ext = (ps == '1);

   always_comb begin
      if (stop || clr)  tick = 1'b0;
      else if (use_ext) tick = ext_rise;
      else              tick = &(div_q | ~mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     div_q <= '0;
      else if (clr)   div_q <= '0;
      else if (!stop) div_q <= div_q + 1'b1;
   end

   AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (div_q == '0)); // R4
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wr_bit,
   input  logic frozen,
   output logic flag
);
   logic arm_q;
   logic do_clr;

   assign do_clr = wr_hit && !wr_bit && arm_q && !frozen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (set_evt)     flag <= 1'b1;
         else if (do_clr) flag <= 1'b0;

         if (do_clr)                           arm_q <= 1'b0;
         else if (rd_hit && flag && !frozen) arm_q <= 1'b1;
      end
   end

   AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && flag) |=> flag); // R6
   AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !arm_q) |=> flag); // R5
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             en,
   input  logic             cmp_mode,
   input  logic             pwm,
   input  logic             tick,
   input  logic             ovf_evt,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             cap_evt,
   output logic             cmp_evt,
   output logic             pin_out
);
   logic in_rise;

   tmr_sync #(.STAGES(SYNC_N)) u_in_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .rise (in_rise)
   );

   assign cmp_evt = en && cmp_mode && tick && (cnt == cmp_val);
   assign cap_evt = en && !cmp_mode && in_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pin_out <= 1'b0;
      else if (!(en && cmp_mode)) pin_out <= 1'b0;
      else if (pwm) begin
         if (cmp_evt && !ovf_evt) pin_out <= 1'b0;
         else if (ovf_evt)        pin_out <= 1'b1;
      end else if (cmp_evt)      pin_out <= ~pin_out;
   end

   AST_PWM_HIGH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmp_mode && pwm && ovf_evt && !cmp_evt) |=> pin_out); // R10
   AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmp_mode && !pwm && cmp_evt) |=> (pin_out != $past(pin_out))); // R9
endmodule

// File: rtl/dual_modulo_timer.sv
module dual_modulo_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              brk_act,
   input  logic              brk_clr_en,
   input  logic              ext_clk,
   input  logic [1:0]        ch_in,
   output logic [1:0]        ch_out,
   output logic              irq_ovf,
   output logic [1:0]        irq_ch
);
   localparam int NCH   = 2;
   localparam int NFLAG = NCH + 1;

   if (DATA_W != 8) begin : g_bad_data
      $error("register layout needs an 8-bit bus");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
      $error("counter must be two bus bytes wide");
   end

   logic              wr_en, rd_en, clr_pulse, tick, ovf_evt, frozen;
   logic              ovf_ie_q, stop_q;
   logic [PS_W-1:0]   ps_q;
   logic [CNT_W-1:0]  cnt_q, mod_q;
   chctl_t            ctl_q   [NCH];
   logic [CNT_W-1:0]  val_q   [NCH];
   logic [CNT_W-1:0]  cmpv    [NCH];
   logic              cap_evt [NCH];
   logic              cmp_evt [NCH];
   logic              ch_en   [NCH];
   logic [NFLAG-1:0]  flag;
   logic              act_sel_q, pend_sel_q;
   logic              buffered;

   assign wr_en     = bus_sel && bus_wr;
   assign rd_en     = bus_sel && !bus_wr;
   assign frozen    = brk_act && !brk_clr_en;
   assign clr_pulse = wr_en && (bus_addr == A_CTRL) && bus_wdata[B_RST];
   assign buffered  = ctl_q[0].buff;
   assign ovf_evt   = tick && (cnt_q == mod_q);

   tmr_tick #(.SYNC_N(SYNC_N)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .ps    (ps_q),
      .stop  (stop_q),
      .clr   (clr_pulse),
      .ext_in(ext_clk),
      .tick  (tick)
   );

   // ---------------- flags: index 0 overflow, 1+i channel i
   for (genvar k = 0; k < NFLAG; k++) begin : g_flag
      localparam logic [ADDR_W-1:0] OWN = (k == 0) ? A_CTRL : ch_ctl_addr(k - 1);
      logic set_k;
      if (k == 0) begin : g_ovf
         assign set_k = ovf_evt;
      end else begin : g_ch
         assign set_k = cap_evt[k-1] || cmp_evt[k-1];
      end
      tmr_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_evt(set_k),
         .rd_hit (rd_en && (bus_addr == OWN)),
         .wr_hit (wr_en && (bus_addr == OWN)),
         .wr_bit (bus_wdata[B_FLAG]),
         .frozen (frozen),
         .flag   (flag[k])
      );
   end

   // ---------------- channels
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i == 0) begin : g_lead
         assign ch_en[i] = 1'b1;
         assign cmpv[i]  = buffered ? val_q[act_sel_q] : val_q[0];
      end else begin : g_follow
         assign ch_en[i] = !buffered;
         assign cmpv[i]  = val_q[i];
      end
      tmr_chan #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_in  (ch_in[i]),
         .en      (ch_en[i]),
         .cmp_mode(ctl_q[i].cmp),
         .pwm     (ctl_q[i].pwm),
         .tick    (tick),
         .ovf_evt (ovf_evt),
         .cnt     (cnt_q),
         .cmp_val (cmpv[i]),
         .cap_evt (cap_evt[i]),
         .cmp_evt (cmp_evt[i]),
         .pin_out (ch_out[i])
      );
      assign irq_ch[i] = flag[i+1] && ctl_q[i].ie;
   end

   assign irq_ovf = flag[0] && ovf_ie_q;

   // ---------------- counter and control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         mod_q    <= '1;
         ovf_ie_q <= 1'b0;
         stop_q   <= 1'b1;
         ps_q     <= '0;
      end else begin
         if (clr_pulse)    cnt_q <= '0;
         else if (ovf_evt) cnt_q <= '0;
         else if (tick)    cnt_q <= cnt_q + 1'b1;

         if (wr_en) begin
            unique case (bus_addr)
               A_CTRL: begin
                  ovf_ie_q <= bus_wdata[B_IE];
                  stop_q   <= bus_wdata[B_STOP];
                  ps_q     <= bus_wdata[PS_W-1:0];
               end
               A_MOD_H: mod_q[CNT_W-1:DATA_W] <= bus_wdata;
               A_MOD_L: mod_q[DATA_W-1:0]     <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // ---------------- channel registers and buffer selection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            ctl_q[i] <= '0;
            val_q[i] <= '0;
         end
         act_sel_q  <= 1'b0;
         pend_sel_q <= 1'b0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (wr_en && bus_addr == ch_ctl_addr(i)) begin
               ctl_q[i].ie   <= bus_wdata[B_IE];
               ctl_q[i].buff <= (i == 0) ? bus_wdata[B_BUF] : 1'b0;
               ctl_q[i].cmp  <= bus_wdata[B_CMP];
               ctl_q[i].pwm  <= bus_wdata[B_PWM];
            end
            if (cap_evt[i])
               val_q[i] <= cnt_q;
            else if (wr_en && bus_addr == ch_hi_addr(i))
               val_q[i][CNT_W-1:DATA_W] <= bus_wdata;
            else if (wr_en && bus_addr == ch_lo_addr(i))
               val_q[i][DATA_W-1:0] <= bus_wdata;
            if (wr_en && buffered &&
                (bus_addr == ch_hi_addr(i) || bus_addr == ch_lo_addr(i)))
               pend_sel_q <= 1'(i);
         end
         if (ovf_evt) act_sel_q <= pend_sel_q;
      end
   end

   // ---------------- read mux
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL:  bus_rdata = {flag[0], ovf_ie_q, stop_q, 1'b0, 1'b0, ps_q};
         A_CNT_H: bus_rdata = cnt_q[CNT_W-1:DATA_W];
         A_CNT_L: bus_rdata = cnt_q[DATA_W-1:0];
         A_MOD_H: bus_rdata = mod_q[CNT_W-1:DATA_W];
         A_MOD_L: bus_rdata = mod_q[DATA_W-1:0];
         default: begin
            for (int i = 0; i < NCH; i++) begin
               if (bus_addr == ch_ctl_addr(i))
                  bus_rdata = {flag[i+1], ctl_q[i].ie, ctl_q[i].buff,
                               ctl_q[i].cmp, ctl_q[i].pwm, 3'b000};
               else if (bus_addr == ch_hi_addr(i))
                  bus_rdata = val_q[i][CNT_W-1:DATA_W];
               else if (bus_addr == ch_lo_addr(i))
                  bus_rdata = val_q[i][DATA_W-1:0];
            end
         end
      endcase
   end

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q == mod_q) |=> (cnt_q == '0)); // R1
   AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flag[0]); // R1
   AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !clr_pulse) |=> (cnt_q == $past(cnt_q))); // R4
   AST_RST_BIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> (cnt_q == '0)); // R4
   AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[0] |=> (val_q[0] == $past(cnt_q))); // R8
   AST_BUF_SWAP_AT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (act_sel_q != $past(act_sel_q)) |-> $past(ovf_evt)); // R11
   AST_IDLE_FOLLOWER: assert property (@(posedge clk) disable iff (!rst_n)
      buffered |=> !ch_out[1]); // R11
endmodule

// File: tb/dual_modulo_timer_bench.sv
module dual_modulo_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       brk_act = 1'b0, brk_clr_en = 1'b0, ext_clk = 1'b0;
   logic [1:0] ch_in = '0;
   logic [1:0] ch_out;
   logic       irq_ovf;
   logic [1:0] irq_ch;

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   string cur_req = "R4";

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_modulo_timer u_dual_modulo_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .brk_act(brk_act), .brk_clr_en(brk_clr_en), .ext_clk(ext_clk),
      .ch_in(ch_in), .ch_out(ch_out), .irq_ovf(irq_ovf), .irq_ch(irq_ch)
   );

   // ---------------- behavioural reference model
   int m_cnt, m_mod, m_div, m_ps;
   bit m_stop, m_ie;
   bit m_flag[3], m_arm[3];
   bit m_cie[2], m_cmp[2], m_pwm[2], m_buf;
   int m_val[2];
   int m_act, m_pend;
   bit m_out[2];
   bit e1, e2, e3;
   bit c1[2], c2[2], c3[2];

   function automatic int model_read(input int a);
      case (a)
         0: return (m_flag[0] << 7) | (m_ie << 6) | (m_stop << 5) | m_ps;
         1: return m_cnt >> 8;
         2: return m_cnt & 255;
         3: return m_mod >> 8;
         4: return m_mod & 255;
         5: return (m_flag[1] << 7) | (m_cie[0] << 6) | (m_buf << 5) | (m_cmp[0] << 4) | (m_pwm[0] << 3);
         6: return m_val[0] >> 8;
         7: return m_val[0] & 255;
         8: return (m_flag[2] << 7) | (m_cie[1] << 6) | (m_cmp[1] << 4) | (m_pwm[1] << 3);
         9: return m_val[1] >> 8;
         10: return m_val[1] & 255;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_mod = 65535; m_div = 0; m_ps = 0; m_stop = 1; m_ie = 0;
         m_buf = 0; m_act = 0; m_pend = 0;
         e1 = 0; e2 = 0; e3 = 0;
         for (int k = 0; k < 3; k++) begin m_flag[k] = 0; m_arm[k] = 0; end
         for (int i = 0; i < 2; i++) begin
            m_cie[i] = 0; m_cmp[i] = 0; m_pwm[i] = 0; m_val[i] = 0; m_out[i] = 0;
            c1[i] = 0; c2[i] = 0; c3[i] = 0;
         end
      end else begin
         bit fz, wrt, rd, clr, tk, ovf;
         bit cap[2], cmpe[2], setf[3];
         int own, a;
         a   = bus_addr;
         fz  = brk_act && !brk_clr_en;
         wrt = bus_sel && bus_wr;
         rd  = bus_sel && !bus_wr;
         clr = wrt && a == 0 && bus_wdata[4];
         if (m_stop || clr) tk = 0;
         else if (m_ps == 7) tk = e2 && !e3;
         else tk = (m_div % (1 << m_ps)) == (1 << m_ps) - 1;
         ovf = tk && m_cnt == m_mod;
         for (int i = 0; i < 2; i++) begin
            bit en; int cv;
            en = !(i == 1 && m_buf);
            cv = (i == 0 && m_buf) ? m_val[m_act] : m_val[i];
            cmpe[i] = en && m_cmp[i] && tk && m_cnt == cv;
            cap[i]  = en && !m_cmp[i] && c2[i] && !c3[i];
            if (!(en && m_cmp[i])) m_out[i] = 0;
            else if (m_pwm[i]) begin
               if (cmpe[i] && !ovf) m_out[i] = 0;
               else if (ovf) m_out[i] = 1;
            end else if (cmpe[i]) m_out[i] = !m_out[i];
         end
         setf[0] = ovf; setf[1] = cmpe[0] || cap[0]; setf[2] = cmpe[1] || cap[1];
         for (int k = 0; k < 3; k++) begin
            bit cf;
            own = (k == 0) ? 0 : (k == 1 ? 5 : 8);
            cf = wrt && a == own && !bus_wdata[7] && m_arm[k] && !fz;
            if (cf) m_arm[k] = 0;
            else if (rd && a == own && m_flag[k] && !fz) m_arm[k] = 1;
            if (setf[k]) m_flag[k] = 1;
            else if (cf) m_flag[k] = 0;
         end
         if (clr) m_cnt = 0;
         else if (ovf) m_cnt = 0;
         else if (tk) m_cnt = (m_cnt + 1) & 65535;
         if (clr) m_div = 0;
         else if (!m_stop) m_div = (m_div + 1) % 64;
         if (ovf) m_act = m_pend;
         for (int i = 0; i < 2; i++) begin
            if (wrt && m_buf && (a == 6 + 3*i || a == 7 + 3*i)) m_pend = i;
            if (cap[i]) m_val[i] = m_cnt_prev_hold(i);
         end
         if (wrt) begin
            case (a)
               0: begin m_ie = bus_wdata[6]; m_stop = bus_wdata[5]; m_ps = bus_wdata[2:0]; end
               3: m_mod = (m_mod & 255) | (bus_wdata << 8);
               4: m_mod = (m_mod & 65280) | bus_wdata;
               5: begin m_cie[0] = bus_wdata[6]; m_buf = bus_wdata[5]; m_cmp[0] = bus_wdata[4]; m_pwm[0] = bus_wdata[3]; end
               8: begin m_cie[1] = bus_wdata[6]; m_cmp[1] = bus_wdata[4]; m_pwm[1] = bus_wdata[3]; end
               default: ;
            endcase
            for (int i = 0; i < 2; i++) begin
               if (!cap[i] && a == 6 + 3*i) m_val[i] = (m_val[i] & 255) | (bus_wdata << 8);
               if (!cap[i] && a == 7 + 3*i) m_val[i] = (m_val[i] & 65280) | bus_wdata;
            end
         end
         e3 = e2; e2 = e1; e1 = ext_clk;
         for (int i = 0; i < 2; i++) begin c3[i] = c2[i]; c2[i] = c1[i]; c1[i] = ch_in[i]; end
         pre_cnt = m_cnt;
      end
   end

   // counter value before the most recent update, used for capture
   int pre_cnt = 0;
   function automatic int m_cnt_prev_hold(input int i);
      return (i >= 0) ? pre_cnt : 0;
   endfunction

   // ---------------- per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e;
         e = model_read(bus_addr);
         n_chk++;
         if (bus_rdata != e[7:0]) begin
            n_fail++;
            $display("FAIL %s rdata addr %0d actual=%0h expected=%0h", cur_req, bus_addr, bus_rdata, e[7:0]);
         end
         n_chk++;
         if (irq_ovf != (m_flag[0] && m_ie) ||
             irq_ch != {m_flag[2] && m_cie[1], m_flag[1] && m_cie[0]}) begin
            n_fail++;
            $display("FAIL %s/R12 irq actual=%b%b expected=%b%b%b", cur_req, irq_ovf, irq_ch,
                     m_flag[0] && m_ie, m_flag[2] && m_cie[1], m_flag[1] && m_cie[0]);
         end
         n_chk++;
         if (ch_out != {m_out[1], m_out[0]}) begin
            n_fail++;
            $display("FAIL %s ch_out actual=%b expected=%b%b", cur_req, ch_out, m_out[1], m_out[0]);
         end
      end
   end

   // ---------------- helpers
   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(input int a, input int d);
      bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
      step(1);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input int a, output int v);
      bus_sel = 1; bus_wr = 0; bus_addr = 4'(a);
      @(negedge clk); v = bus_rdata;
      step(1);
      bus_sel = 0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_high(input int idx, input int n, output int hi, output int tog);
      bit prev;
      hi = 0; tog = 0; prev = ch_out[idx];
      repeat (n) begin
         @(negedge clk);
         if (ch_out[idx]) hi++;
         if (ch_out[idx] != prev) tog++;
         prev = ch_out[idx];
      end
      @(posedge clk); #1;
   endtask

   // ---------------- watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus
   initial begin
      int v, w, hi, tg;
      step(3);
      rst_n = 1;
      step(1);

      cur_req = "R4";
      rd(0, v); chk("R4 reset control", v, 8'h20);
      rd(2, v); chk("R4 reset counter", v, 0);
      chk("R1 reset irq_ovf", irq_ovf, 0);

      cur_req = "R1";
      wr(3, 0); wr(4, 4); wr(0, 8'h40);
      step(10);
      chk("R1 overflow irq", irq_ovf, 1);
      wr(0, 8'h60);
      rd(2, v); chk("R1 count within modulo", v <= 4, 1);

      cur_req = "R5";
      wr(0, 8'h60);
      chk("R5 blind write keeps flag", irq_ovf, 1);
      rd(0, v); chk("R5 flag bit reads 1", v >> 7, 1);
      wr(0, 8'h60);
      chk("R5 read then write clears", irq_ovf, 0);
      wr(0, 8'hE0);
      chk("R5 write 1 does not set", irq_ovf, 0);

      cur_req = "R4";
      rd(2, v); step(5); rd(2, w);
      chk("R4 stop holds count", w, v);
      wr(0, 8'h70);
      rd(2, v); chk("R4 reset bit clears count", v, 0);
      rd(0, v); chk("R4 reset bit reads 0", v, 8'h60);

      cur_req = "R2";
      wr(3, 8'hFF); wr(4, 8'hFF); wr(0, 8'h12);
      step(20);
      wr(0, 8'h22);
      rd(2, v); chk("R2 divide by 4 over 20 cycles", v, 5);

      cur_req = "R3";
      wr(0, 8'h17);
      for (int n = 0; n < 6; n++) begin
         ext_clk = 1; step(3); ext_clk = 0; step(3);
      end
      step(4);
      wr(0, 8'h27);
      rd(2, v); chk("R3 external edges counted", v, 6);

      cur_req = "R6";
      wr(3, 0); wr(4, 2); wr(0, 8'h50);
      step(8);
      wr(0, 8'h60);
      chk("R6 flag set before break", irq_ovf, 1);
      brk_act = 1;
      rd(0, v); wr(0, 8'h60);
      chk("R6 frozen break keeps flag", irq_ovf, 1);
      brk_act = 0;
      wr(0, 8'h60);
      chk("R6 frozen read did not arm", irq_ovf, 1);
      rd(0, v);
      brk_act = 1; wr(0, 8'h60);
      chk("R6 armed flag held in break", irq_ovf, 1);
      brk_act = 0; wr(0, 8'h60);
      chk("R6 second step after break clears", irq_ovf, 0);

      cur_req = "R7";
      wr(0, 8'h50); step(8); wr(0, 8'h60);
      brk_act = 1; brk_clr_en = 1;
      rd(0, v); wr(0, 8'h60);
      chk("R7 clear allowed in break", irq_ovf, 0);
      brk_act = 0; step(2);
      chk("R7 stays cleared after break", irq_ovf, 0);
      brk_clr_en = 0;

      cur_req = "R8";
      wr(5, 8'h40); wr(3, 8'hFF); wr(4, 8'hFF); wr(0, 8'h10);
      step(10);
      ch_in[0] = 1; step(5); ch_in[0] = 0;
      rd(7, v); chk("R8 captured count", v, 12);
      chk("R12 capture irq", irq_ch[0], 1);
      rd(5, v); wr(5, 8'h40);
      chk("R12 channel flag two-step clear", irq_ch[0], 0);

      cur_req = "R9";
      wr(0, 8'h30); wr(5, 0); wr(8, 8'h50); wr(9, 0); wr(10, 5);
      wr(3, 0); wr(4, 9); wr(0, 8'h00);
      step(3);
      count_high(1, 50, hi, tg);
      chk("R9 toggles per 5 periods", tg, 5);
      chk("R12 compare irq", irq_ch[1], 1);

      cur_req = "R10";
      wr(8, 0); wr(6, 0); wr(7, 3); wr(5, 8'h18);
      step(20);
      count_high(0, 50, hi, tg);
      chk("R10 PWM high cycles", hi, 20);

      cur_req = "R11";
      wr(5, 8'h38);
      step(15);
      count_high(0, 50, hi, tg);
      chk("R11 buffered width from ch0 reg", hi, 20);
      wr(9, 0); wr(10, 6);
      step(15);
      count_high(0, 50, hi, tg);
      chk("R11 width from ch1 reg after overflow", hi, 35);
      count_high(1, 50, hi, tg);
      chk("R11 follower pin idle", hi, 0);
      wr(6, 0); wr(7, 1);
      step(15);
      count_high(0, 50, hi, tg);
      chk("R11 back to ch0 reg", hi, 10);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule